// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a three-wire stereo PCM stream and turns it into one parallel sample for each channel. The three wires are a bit clock, a word clock that names the channel, and a data line. The bit clock is the block's own clock. On each rising edge the block samples the word clock and the data line together. This interval is called a slot. A change in the word-clock level, compared with the previous slot, starts a new half-frame. The word that belongs to the half-frame just ended is then taken.

Two static inputs set how words are placed inside a half-frame:

- The format select chooses between I2S placement and LSB-justified placement. In I2S placement the word begins one slot after the word-clock change. In LSB-justified placement the word ends on the last slot before the change.
- The length select chooses a 16-bit or an 18-bit word.

The outputs are a signed left sample and a signed right sample, both 18 bits wide. A 16-bit word is sign-extended to fill them. Both outputs change together, and a one-cycle valid strobe marks each completed stereo frame.

Top module: `serial_audio_rx`

## Requirements
- R1: The data line and word clock are sampled on the rising edge of `bclk`. Words are two's complement and arrive most-significant bit first.
- R2: With `fmt_lsbj`=0 (I2S), slot 0 of a half-frame is the slot in which the sampled word clock first differs from the previous slot. The N word bits occupy slots 1..N. Slot 0 and every slot after N are ignored, so a half-frame needs at least N+1 slots.
- R3: With `fmt_lsbj`=1 (LSB-justified), the word is the last N slots before the next word-clock change, with the LSB in the final slot. All earlier slots are ignored. A half-frame needs at least N slots and may have up to 64.
- R4: In both formats, a half-frame with `wclk` low carries the left channel and a half-frame with `wclk` high carries the right channel.
- R5: With `len18`=0 the word is 16 bits, and output bits 17 and 16 copy bit 15.
- R6: A right half-frame ends at the rising edge where `wclk` is first seen low again. In the cycle after that edge:
  - `frame_valid` is high for exactly one cycle.
  - `left_out` and `right_out` change in the same cycle.
  - The outputs are otherwise held.
- R7: An active-low asynchronous `rst_n` clears both outputs and `frame_valid`. No strobe is issued until a left half-frame that began with a word-clock change after reset, and the right half-frame after it, have both completed.
- R8: `len18`=1 selects an 18-bit word (N=18), and `len18`=0 selects N=16. The two selects are expected to change only between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word clock: low = left, high = right |
| sdata | input | 1 | Serial audio data |
| fmt_lsbj | input | 1 | 0 = I2S placement, 1 = LSB-justified |
| len18 | input | 1 | 0 = 16-bit words, 1 = 18-bit words |
| left_out | output | 18 | Signed left sample |
| right_out | output | 18 | Signed right sample |
| frame_valid | output | 1 | One-cycle strobe per completed stereo frame |

## Verification
The hardest state to reach is a reset released in the middle of a left half-frame. After such a reset the word clock is already low, so no change is seen for that partial word. The bench asserts reset while streaming left slots and releases it before the half-frame ends. It then finishes a full right half-frame and confirms that no strobe appears and that the outputs stay cleared. The next full frame must then produce a strobe. Half-frame lengths at the minimum for each format are also streamed, because there the junk slots vanish and the word edges meet the word-clock change directly.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WMAX = 18,
  parameter int WMIN = 16
) (
  input  logic            bclk,
  input  logic            rst_n,
  input  logic            wclk,
  input  logic            sdata,
  input  logic            fmt_lsbj,
  input  logic            len18,
  output logic [WMAX-1:0] left_out,
  output logic [WMAX-1:0] right_out,
  output logic            frame_valid
);
  localparam int CW = $clog2(WMAX + 2);
  localparam logic [CW-1:0] SLOT_SAT = CW'(WMAX + 1);

  logic            wclk_q, armed, started, left_ok;
  logic [CW-1:0]   slot_q, slot_now, word_len;
  logic [WMAX-1:0] sh, left_hold, word_ext;
  logic            wc_edge, take_bit;

  assign wc_edge  = armed && (wclk != wclk_q);
  assign slot_now = wc_edge ? '0 : ((slot_q == SLOT_SAT) ? slot_q : slot_q + 1'b1);
  assign word_len = len18 ? CW'(WMAX) : CW'(WMIN);
  assign take_bit = fmt_lsbj || ((slot_now != '0) && (slot_now <= word_len));
  assign word_ext = len18 ? sh : {{(WMAX-WMIN){sh[WMIN-1]}}, sh[WMIN-1:0]};

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q      <= 1'b0;
      armed       <= 1'b0;
      started     <= 1'b0;
      left_ok     <= 1'b0;
      slot_q      <= '0;
      sh          <= '0;
      left_hold   <= '0;
      left_out    <= '0;
      right_out   <= '0;
      frame_valid <= 1'b0;
    end else begin
      wclk_q      <= wclk;
      armed       <= 1'b1;
      slot_q      <= slot_now;
      frame_valid <= 1'b0;
      if (take_bit) sh <= {sh[WMAX-2:0], sdata};
      if (wc_edge) begin
        started <= 1'b1;
        if (!wclk_q) begin
          left_hold <= word_ext;
          left_ok   <= started;
        end else if (left_ok) begin
          left_out    <= left_hold;
          right_out   <= word_ext;
          frame_valid <= 1'b1;
        end
      end
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R6
  hold_outputs_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_valid |-> ($stable(left_out) && $stable(right_out)));

  // R4
  valid_after_left_start_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |-> !$past(wclk));

  // R5
  sign_ext_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_valid && !len18) |->
      (left_out[WMAX-1:WMIN] == {(WMAX-WMIN){left_out[WMIN-1]}}) &&
      (right_out[WMAX-1:WMIN] == {(WMAX-WMIN){right_out[WMIN-1]}}));
endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic bclk = 1'b0;
  logic rst_n, wclk, sdata, fmt_lsbj, len18;
  logic [17:0] left_out, right_out;
  logic frame_valid;
  int checks = 0, failures = 0, nvalid = 0;
  bit done = 0;

  always #4 bclk = ~bclk;

  serial_audio_rx dut_i (
    .bclk(bclk), .rst_n(rst_n), .wclk(wclk), .sdata(sdata),
    .fmt_lsbj(fmt_lsbj), .len18(len18),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid));

  always @(negedge bclk) if (frame_valid) nvalid++;

  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'd32, 18'h08000, 18'h07FFF},
    {1'b0, 1'b0, 7'd17, 18'h0ABCD, 18'h01234},
    {1'b0, 1'b1, 7'd64, 18'h20001, 18'h1FFFE},
    {1'b0, 1'b1, 7'd19, 18'h12345, 18'h2FEDC},
    {1'b1, 1'b0, 7'd16, 18'h0FFFF, 18'h00001},
    {1'b1, 1'b0, 7'd64, 18'h3C0DE, 18'h07F00},
    {1'b1, 1'b1, 7'd18, 18'h3FFFF, 18'h00000},
    {1'b1, 1'b1, 7'd40, 18'h15A5A, 18'h2A5A5}
  };

  function automatic logic [17:0] ext(input logic l18, input logic [17:0] w);
    return l18 ? w : {{2{w[15]}}, w[15:0]};
  endfunction

  function automatic logic bitof(input logic fm, input logic l18, input int half,
                                 input int s, input logic [17:0] w, input logic seed);
    int n = l18 ? 18 : 16;
    int pos;
    logic jb = s[0] ^ seed;
    if (!fm) begin
      pos = s - 1;
      return (s >= 1 && s <= n) ? w[n-1-pos] : jb;
    end
    pos = s - (half - n);
    return (pos >= 0) ? w[n-1-pos] : jb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a negedge, return at the following negedge
  task automatic slot(input logic w, input logic d);
    wclk = w; sdata = d;
    @(negedge bclk);
  endtask

  task automatic play_frame(input logic fm, input logic l18, input int half,
                            input logic [17:0] l, input logic [17:0] r, input logic seed);
    fmt_lsbj = fm; len18 = l18;
    for (int s = 1; s < half; s++) slot(1'b0, bitof(fm, l18, half, s, l, seed));
    for (int s = 0; s < half; s++) slot(1'b1, bitof(fm, l18, half, s, r, ~seed));
    slot(1'b0, seed);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 18'h0, 18'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nb;
    logic [17:0] lastl, lastr;
    rst_n = 1'b0; wclk = 1'b1; sdata = 1'b0; fmt_lsbj = 1'b0; len18 = 1'b0;
    repeat (3) @(negedge bclk);
    #1;
    // R7 reset state
    chk(left_out == 18'h0 && right_out == 18'h0, "R7 reset outputs", left_out, 18'h0);
    chk(frame_valid == 1'b0, "R7 reset valid", {17'h0, frame_valid}, 18'h0);
    @(negedge bclk);
    rst_n = 1'b1;
    repeat (3) slot(1'b1, 1'b0);
    slot(1'b0, 1'b1);
    lastl = '0; lastr = '0;
    for (int i = 0; i < NV; i++) begin
      logic fm = VEC[i][44];
      logic l18 = VEC[i][43];
      int half = int'(VEC[i][42:36]);
      logic [17:0] l = VEC[i][35:18];
      logic [17:0] r = VEC[i][17:0];
      string tg = fm ? (l18 ? "R1 R3 R4 R8" : "R1 R3 R4 R5 R8")
                     : (l18 ? "R1 R2 R4 R8" : "R1 R2 R4 R5 R8");
      nb = nvalid;
      play_frame(fm, l18, half, l, r, i[0]);
      chk(nvalid == nb + 1 && frame_valid, "R6 one strobe per frame",
          18'(nvalid - nb), 18'h1);
      chk(left_out == ext(l18, l), {tg, " left"}, left_out, ext(l18, l));
      chk(right_out == ext(l18, r), {tg, " right"}, right_out, ext(l18, r));
      lastl = ext(l18, l); lastr = ext(l18, r);
    end
    // R6 outputs hold with no strobe during a following half-frame
    nb = nvalid;
    for (int s = 1; s < 24; s++) slot(1'b0, s[1]);
    #1;
    chk(nvalid == nb && !frame_valid, "R6 no strobe mid-frame", 18'(nvalid - nb), 18'h0);
    chk(left_out == lastl && right_out == lastr, "R6 outputs held", left_out, lastl);
    // R7 reset in the middle of a left half-frame
    rst_n = 1'b0;
    slot(1'b0, 1'b1); slot(1'b0, 1'b0);
    #1;
    chk(left_out == 18'h0 && right_out == 18'h0, "R7 mid-frame reset clears", left_out, 18'h0);
    rst_n = 1'b1;
    fmt_lsbj = 1'b0; len18 = 1'b0;
    nb = nvalid;
    for (int s = 0; s < 10; s++) slot(1'b0, s[0]);
    for (int s = 0; s < 32; s++) slot(1'b1, bitof(1'b0, 1'b0, 32, s, 18'h05555, 1'b0));
    slot(1'b0, 1'b0);
    #1;
    chk(nvalid == nb, "R7 no strobe after partial frame", 18'(nvalid - nb), 18'h0);
    chk(left_out == 18'h0 && right_out == 18'h0, "R7 outputs stay cleared", right_out, 18'h0);
    nb = nvalid;
    play_frame(1'b0, 1'b0, 32, 18'h0C001, 18'h04321, 1'b1);
    chk(nvalid == nb + 1, "R7 strobe on first full frame", 18'(nvalid - nb), 18'h1);
    chk(left_out == ext(1'b0, 18'h0C001), "R7 R5 left after reset", left_out, ext(1'b0, 18'h0C001));
    chk(right_out == 18'h04321, "R7 right after reset", right_out, 18'h04321);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule